// File: doc/BRIEF.md
# ADC Conversion Sequencer and Register Front End

This block is the digital side of a 10-bit successive-approximation converter. A host reaches it through a byte-wide register port with two writable registers. The select register holds the reference choice, the channel/gain code and the result justification. The control register holds enable, start, trigger mode, the completion flag and the interrupt enable. Conversions are timed in converter clock periods, which arrive as a one-cycle `cnv_tick` enable on the system clock. The reference and channel fields seen by the analog path are held stable for the whole of each conversion.

A conversion can be started three ways: by a host write of the start bit, by a rising edge on the trigger input in auto mode, or by the block itself in free-running mode. At the end of a conversion the value on `conv_data` is captured, the completion flag is raised, and an interrupt request can follow. The captured value reads back through two byte registers, justified to the left or to the right.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low, and `ref_act` and `chan_act` are zero.
- R2: A conversion lasts 13 `cnv_tick` periods. The first conversion started after enable goes from 0 to 1 lasts 25 periods instead, whether its start comes in the same write as the enable or in a later one. The count runs from the start edge to the tick on which the flag is set.
- R3: Control bit 1 (start) reads 1 while a conversion runs and 0 otherwise. A start is accepted only when the written byte also has bit 0 (enable) set. Writing 0 to bit 1 starts nothing.
- R4: `ref_act`/`chan_act` take the select register's bits 7:6 and 4:0 while the block is idle and at each conversion end. A select write during a conversion does not change them until that conversion completes.
- R5: Select bit 5 chooses the justification and takes effect on the next read, even mid-conversion. With bit 5 set, the result fills bits 15:6 of {high,low}. With it clear, the result fills bits 9:0. Unused bits read 0.
- R6: On the final tick the result is captured and control bit 4 (flag) is set in the same edge. The flag clears on a control write with bit 4 set, or on an `irq_ack` pulse. A completion in the same cycle as a clear wins.
- R7: `irq` is high exactly when the flag, control bit 5 (interrupt enable) and `gie` are all high.
- R8: Writing control bit 0 as 0 during a conversion aborts it on the next edge. The flag stays clear and the result registers keep their old value.
- R9: With control bit 2 (auto) set and bit 3 (free) clear, a rising edge on `trig_in` starts a conversion. With both set, one start write begins conversion after conversion, each 13 periods long, until the block is disabled.
- R10: A trigger edge or start write that arrives during a conversion is dropped, not queued, and produces no extra completion.
- R11: Address 0 is select, 1 is control, 2 is result low, 3 is result high. Other addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_tick | input | 1 | One-cycle pulse per converter clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| trig_in | input | 1 | Auto-trigger source |
| conv_data | input | 10 | Converter result, sampled on the final tick |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Conversion-complete interrupt request |
| ref_act | output | 2 | Reference select in force for the analog path |
| chan_act | output | 5 | Channel/gain code in force for the analog path |

## Verification
The hardest condition to reach is a conversion that must run its full course while other requests compete with it: select writes, justification flips, a second trigger edge and a redundant start, all landing mid-conversion. The stimulus issues these writes a few ticks after a start, with the tick rate set to one per three clocks so that register traffic falls between ticks. It then measures the tick count of each completion against a queue of expected lengths. The abort and the free-running chain are reached the same way: an enable-clear write lands inside a running conversion, and a single start is followed by three back-to-back completions, each acknowledged by the monitor.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int unsigned BYTE_W = 8;

   // register addresses
   localparam int unsigned ADR_SEL = 0;
   localparam int unsigned ADR_CTL = 1;
   localparam int unsigned ADR_RLO = 2;
   localparam int unsigned ADR_RHI = 3;

   // control register bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_GO   = 1;
   localparam int unsigned CB_AUTO = 2;
   localparam int unsigned CB_FREE = 3;
   localparam int unsigned CB_FLAG = 4;
   localparam int unsigned CB_IE   = 5;

   // select register layout, MSB first
   typedef struct packed {
      logic [1:0] refs;
      logic       left;
      logic [4:0] chan;
   } sel_t;
endpackage

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
   parameter int unsigned RES_W = 10
) (
   input  logic             left_i,
   input  logic [RES_W-1:0] res_i,
   output logic [7:0]       lo_o,
   output logic [7:0]       hi_o
);
   localparam int unsigned PAIR_W = 16;
   localparam int unsigned PAD    = PAIR_W - RES_W;

   logic [PAIR_W-1:0] pair;

   generate
      if (RES_W > PAIR_W || RES_W < 1) begin : g_bad_w
         $error("adc_result_fmt: RES_W must be 1..16");
      end
      if (PAD == 0) begin : g_full
         assign pair = res_i;
      end else begin : g_pad
         logic [PAIR_W-1:0] lft, rgt;
         assign lft  = {res_i, {PAD{1'b0}}};
         assign rgt  = {{PAD{1'b0}}, res_i};
         assign pair = left_i ? lft : rgt;
      end
   endgenerate

   assign lo_o = pair[7:0];
   assign hi_o = pair[15:8];
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W     = 10,
   parameter int unsigned NORM_LEN  = 13,
   parameter int unsigned FIRST_LEN = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             en_rise_i,
   input  logic             start_wr_i,
   input  logic             auto_i,
   input  logic             free_i,
   input  logic             trig_i,
   input  logic [RES_W-1:0] conv_i,
   input  sel_t             sel_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] res_o,
   output sel_t             act_o
);
   localparam int unsigned CW = $clog2(FIRST_LEN + 1);
   localparam logic [CW-1:0] LD_FIRST = CW'(FIRST_LEN - 1);
   localparam logic [CW-1:0] LD_NORM  = CW'(NORM_LEN - 1);

   generate
      if (NORM_LEN < 2 || FIRST_LEN < NORM_LEN) begin : g_bad_len
         $error("adc_sequencer: need 2 <= NORM_LEN <= FIRST_LEN");
      end
   endgenerate

   logic             busy_q, init_q, trig_q;
   logic [CW-1:0]    cnt_q;
   logic [RES_W-1:0] res_q;
   sel_t             act_q;
   logic             trig_rise, start_req, done;

   assign trig_rise = trig_i & ~trig_q;
   assign start_req = !busy_q &&
                      (start_wr_i || (en_i && auto_i && !free_i && trig_rise));
   assign done      = busy_q && en_i && tick_i && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         init_q <= 1'b0;
         trig_q <= 1'b0;
         cnt_q  <= '0;
         res_q  <= '0;
         act_q  <= '0;
      end else begin
         trig_q <= trig_i;
         if (!busy_q || done) act_q <= sel_i;
         if (done)            res_q <= conv_i;

         if (start_req) begin
            busy_q <= 1'b1;
            cnt_q  <= (init_q || en_rise_i) ? LD_FIRST : LD_NORM;
         end else if (!en_i) begin
            busy_q <= 1'b0;
         end else if (busy_q && tick_i) begin
            if (cnt_q == '0) begin
               if (auto_i && free_i) cnt_q  <= LD_NORM;
               else                  busy_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         if (start_req)      init_q <= 1'b0;
         else if (en_rise_i) init_q <= 1'b1;
         else if (!en_i)     init_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign done_o = done;
   assign res_o  = res_q;
   assign act_o  = act_q;

   // R4
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(done)) |-> $stable(act_q));

   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !start_wr_i) |=> !busy_q);

   // R10
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && en_i && !tick_i) |=> (busy_q && cnt_q == $past(cnt_q)));

   // R2
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LD_FIRST));
endmodule

// File: rtl/adc_regs.sv
module adc_regs
   import adc_seq_pkg::*;
#(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   input  logic          done_i,
   input  logic          busy_i,
   input  logic          irq_ack_i,
   input  logic          gie_i,
   input  logic [7:0]    res_lo_i,
   input  logic [7:0]    res_hi_i,
   output sel_t          sel_o,
   output logic          en_o,
   output logic          auto_o,
   output logic          free_o,
   output logic          start_wr_o,
   output logic          en_rise_o,
   output logic          irq_o,
   output logic [7:0]    rdata_o
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("adc_regs: AW must be at least 2");
      end
   endgenerate

   sel_t       sel_q;
   logic       en_q, auto_q, free_q, ie_q, flag_q;
   logic       wr_sel, wr_ctl, flag_clr;
   logic [7:0] ctl_rd;

   assign wr_sel   = wr_en && (addr == AW'(ADR_SEL));
   assign wr_ctl   = wr_en && (addr == AW'(ADR_CTL));
   assign flag_clr = irq_ack_i || (wr_ctl && wdata[CB_FLAG]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         en_q   <= 1'b0;
         auto_q <= 1'b0;
         free_q <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (wr_sel) sel_q <= sel_t'(wdata);
         if (wr_ctl) begin
            en_q   <= wdata[CB_EN];
            auto_q <= wdata[CB_AUTO];
            free_q <= wdata[CB_FREE];
            ie_q   <= wdata[CB_IE];
         end
         if (done_i)        flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   assign start_wr_o = wr_ctl && wdata[CB_EN] && wdata[CB_GO];
   assign en_rise_o  = wr_ctl && wdata[CB_EN] && !en_q;
   assign irq_o      = flag_q && ie_q && gie_i;
   assign sel_o      = sel_q;
   assign en_o       = en_q;
   assign auto_o     = auto_q;
   assign free_o     = free_q;

   always_comb begin
      ctl_rd          = '0;
      ctl_rd[CB_EN]   = en_q;
      ctl_rd[CB_GO]   = busy_i;
      ctl_rd[CB_AUTO] = auto_q;
      ctl_rd[CB_FREE] = free_q;
      ctl_rd[CB_FLAG] = flag_q;
      ctl_rd[CB_IE]   = ie_q;
   end

   always_comb begin
      if (addr == AW'(ADR_SEL))      rdata_o = sel_q;
      else if (addr == AW'(ADR_CTL)) rdata_o = ctl_rd;
      else if (addr == AW'(ADR_RLO)) rdata_o = res_lo_i;
      else if (addr == AW'(ADR_RHI)) rdata_o = res_hi_i;
      else                           rdata_o = '0;
   end

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> flag_q);

   // R6
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !done_i) |=> !flag_q);

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !irq_o);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W     = 10,
   parameter int unsigned NORM_LEN  = 13,
   parameter int unsigned FIRST_LEN = 25,
   parameter int unsigned AW        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnv_tick,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic             trig_in,
   input  logic [RES_W-1:0] conv_data,
   input  logic             irq_ack,
   input  logic             gie,
   output logic             irq,
   output logic [1:0]       ref_act,
   output logic [4:0]       chan_act
);
   sel_t             sel, act;
   logic             en, auto_m, free_m, start_wr, en_rise, busy, done;
   logic [RES_W-1:0] res;
   logic [7:0]       res_lo, res_hi;

   adc_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .done_i(done), .busy_i(busy), .irq_ack_i(irq_ack), .gie_i(gie),
      .res_lo_i(res_lo), .res_hi_i(res_hi), .sel_o(sel), .en_o(en),
      .auto_o(auto_m), .free_o(free_m), .start_wr_o(start_wr),
      .en_rise_o(en_rise), .irq_o(irq), .rdata_o(rdata)
   );

   adc_sequencer #(.RES_W(RES_W), .NORM_LEN(NORM_LEN), .FIRST_LEN(FIRST_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick_i(cnv_tick), .en_i(en),
      .en_rise_i(en_rise), .start_wr_i(start_wr), .auto_i(auto_m),
      .free_i(free_m), .trig_i(trig_in), .conv_i(conv_data), .sel_i(sel),
      .busy_o(busy), .done_o(done), .res_o(res), .act_o(act)
   );

   adc_result_fmt #(.RES_W(RES_W)) u_fmt (
      .left_i(sel.left), .res_i(res), .lo_o(res_lo), .hi_o(res_hi)
   );

   assign ref_act  = act.refs;
   assign chan_act = act.chan;
endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
   localparam logic [7:0] EN = 8'h01, GO = 8'h02, AUT = 8'h04, FRE = 8'h08,
                          FLG = 8'h10, IE = 8'h20;

   logic       clk = 0, rst_n = 0, cnv_tick = 0, wr_en = 0, trig_in = 0;
   logic       irq_ack = 0, gie = 0;
   logic [2:0] addr = 0;
   logic [7:0] wdata = 0, rdata;
   logic [9:0] conv_data = 0;
   logic       irq;
   logic [1:0] ref_act;
   logic [4:0] chan_act;

   int vecs = 0, errs = 0, tcount = 0, mark = 0, n_done = 0;
   bit mon_on = 0, prev_irq = 0, ended = 0;
   int exp_q[$];

   always #10 clk = ~clk;

   adc_conv_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cnv_tick(cnv_tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .trig_in(trig_in),
      .conv_data(conv_data), .irq_ack(irq_ack), .gie(gie), .irq(irq),
      .ref_act(ref_act), .chan_act(chan_act)
   );

   always @(posedge clk) if (cnv_tick) tcount <= tcount + 1;

   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         cnv_tick = (ph == 0);
         ph = (ph + 1) % 3;
      end
   end

   task automatic chk(string tag, int act, int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done(int target);
      while (n_done < target) @(negedge clk);
   endtask

   task automatic wait_idle();
      logic [7:0] d;
      for (int i = 0; i < 500; i++) begin
         rd(3'd1, d);
         if (!d[1]) break;
      end
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_in = 1;
      @(negedge clk); trig_in = 0;
   endtask

   // scoreboard monitor: each completion is matched against a queued length
   initial begin
      forever begin
         @(negedge clk);
         irq_ack = 0;
         if (mon_on && irq && !prev_irq) begin
            n_done++;
            if (exp_q.size() == 0) chk("R10 unexpected completion", 1, 0);
            else chk("R2 conversion length in ticks", tcount - mark, exp_q.pop_front());
            mark = tcount;
            irq_ack = 1;
         end
         prev_irq = irq;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      int nd;
      wait_clk(5);
      rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(3'(a), d);
         chk("R1 register reset", d, 0);
      end
      chk("R1 irq after reset", irq, 0);
      chk("R1 chan_act after reset", chan_act, 0);
      chk("R1 ref_act after reset", ref_act, 0);
      rd(3'd5, d); chk("R11 unmapped read", d, 0);
      wr(3'd6, 8'hFF);
      rd(3'd6, d); chk("R11 unmapped write ignored", d, 0);
      rd(3'd0, d); chk("R11 select untouched", d, 0);

      // enable and start together: long first conversion
      mon_on = 1; gie = 1; conv_data = 10'h2A5;
      exp_q.push_back(25);
      wr(3'd1, EN | GO | IE); mark = tcount;
      rd(3'd1, d); chk("R3 start bit busy", d[1], 1);
      wait_done(1);
      rd(3'd2, d); chk("R5 right low", d, 8'hA5);
      rd(3'd3, d); chk("R5 right high", d, 8'h02);
      rd(3'd1, d); chk("R6 ack clears flag", d[4], 0);
      chk("R3 start bit idle", d[1], 0);

      wr(3'd0, 8'h20);
      rd(3'd3, d); chk("R5 left high", d, 8'hA9);
      rd(3'd2, d); chk("R5 left low", d, 8'h40);

      // start bit written as zero
      wr(3'd1, EN | IE);
      rd(3'd1, d); chk("R3 zero start no effect", d[1], 0);
      wait_clk(60);
      chk("R3 no completion from zero start", n_done, 1);

      // select deferral and immediate justification
      conv_data = 10'h15A;
      exp_q.push_back(13);
      wr(3'd1, EN | GO | IE); mark = tcount;
      wr(3'd0, 8'hC9);
      @(negedge clk);
      chk("R4 chan held mid-conversion", chan_act, 0);
      chk("R4 ref held mid-conversion", ref_act, 0);
      rd(3'd3, d); chk("R5 justify change mid-conversion", d, 8'h02);
      wait_done(2);
      @(negedge clk);
      chk("R4 chan after completion", chan_act, 9);
      chk("R4 ref after completion", ref_act, 3);
      rd(3'd2, d); chk("R6 result low captured", d, 8'h5A);
      rd(3'd3, d); chk("R6 result high captured", d, 8'h01);

      // flag write-one-clear and interrupt gating
      mon_on = 0; gie = 0;
      wr(3'd1, EN | GO | IE);
      wait_idle();
      @(negedge clk);
      chk("R7 irq masked by gie", irq, 0);
      rd(3'd1, d); chk("R6 flag set", d[4], 1);
      gie = 1;
      @(negedge clk);
      chk("R7 irq asserted", irq, 1);
      wr(3'd1, EN | IE | FLG);
      @(negedge clk);
      chk("R6 w1c clears irq", irq, 0);
      rd(3'd1, d); chk("R6 w1c clears flag", d[4], 0);
      wr(3'd1, EN | GO);
      wait_idle();
      @(negedge clk);
      chk("R7 irq masked by enable bit", irq, 0);
      rd(3'd1, d); chk("R6 flag set without ie", d[4], 1);
      wr(3'd1, EN | FLG);
      rd(3'd1, d); chk("R6 flag cleared", d[4], 0);

      // abort
      mon_on = 1; conv_data = 10'h3FF;
      wr(3'd1, EN | GO | IE);
      wait_clk(10);
      wr(3'd1, 8'h00);
      rd(3'd1, d); chk("R8 abort stops busy", d[1], 0);
      wait_clk(120);
      chk("R8 no completion after abort", n_done, 2);
      rd(3'd1, d); chk("R8 flag clear after abort", d[4], 0);
      rd(3'd2, d); chk("R8 result kept", d, 8'h5A);

      // enable, then start in a later write: long again
      wr(3'd1, EN | IE);
      exp_q.push_back(25);
      wr(3'd1, EN | GO | IE); mark = tcount;
      wait_done(3);
      rd(3'd2, d); chk("R2 result after long start", d, 8'hFF);
      rd(3'd3, d); chk("R2 result high after long start", d, 8'h03);

      // auto trigger with dropped requests
      wr(3'd1, EN | AUT | IE);
      exp_q.push_back(13);
      pulse_trig(); mark = tcount;
      wait_clk(12);
      rd(3'd1, d); chk("R9 trigger started conversion", d[1], 1);
      pulse_trig();
      wr(3'd1, EN | GO | AUT | IE);
      wait_done(4);
      wait_clk(90);
      chk("R10 requests during conversion dropped", n_done, 4);

      // free running
      wr(3'd1, EN | AUT | FRE | IE);
      pulse_trig();
      wait_clk(60);
      chk("R9 trigger ignored in free mode", n_done, 4);
      repeat (3) exp_q.push_back(13);
      wr(3'd1, EN | GO | AUT | FRE | IE); mark = tcount;
      wait_done(7);
      wr(3'd1, 8'h00);
      nd = n_done;
      wait_clk(120);
      chk("R9 free run stops on disable", n_done, nd);
      chk("R9 free run completions", nd, 7);
      finish_run();
   end
endmodule